// File: doc/BRIEF.md
# Programmable Input Debounce and Glitch Filter

This block sits between one raw digital input pin and the counter logic that consumes it. The input first crosses into the 48 MHz clock domain through a two-stage synchronizer. It is then conditioned by a filter with a four-bit time setting. The setting picks one of sixteen hold times between 500 ns and 25 ms, and a mode input picks one of two filter behaviours.

In de-bounce mode the filtered level moves only after the synchronized input has stayed at a new value for the whole selected time. Any bounce back restarts the wait. In glitch-detect mode the filtered level tracks the synchronized input with no delay. Every level interval shorter than the selected time, measured between two transitions, raises a sticky flag. The flag stays set until the clear input is pulsed.

A one-cycle strobe marks each filtered transition in the chosen direction, rising or falling. Counters use this strobe as their count enable.

Top module: `sig_conditioner`

## Requirements
- R1: The raw input passes through exactly two synchronizer flops. In glitch-detect mode, a change on `raw_in` sampled at one clock edge appears on `level_out` after the third rising edge, counting that edge.
- R2: `time_sel` values 0 to 15 select hold times of 24, 48, 96, 240, 480, 960, 2400, 4800, 9600, 24000, 48000, 96000, 240000, 480000, 960000 and 1200000 clock cycles. At 48 MHz these are 0.5 µs to 25 ms.
- R3: In de-bounce mode (`mode_glitch` = 0), a new raw level held for N = hold time consecutive samples changes `level_out` on the (N+2)th rising edge after the first sample of the new level.
- R4: In de-bounce mode, a new level that lasts fewer than N samples before returning leaves `level_out` unchanged, and the wait restarts from zero.
- R5: In glitch-detect mode (`mode_glitch` = 1), `level_out` equals the synchronized input delayed by one register.
- R6: In glitch-detect mode, `glitch_flag` is set when a synchronized level interval that both starts and ends with a transition lasts fewer than N cycles. An interval of N or more cycles does not set it. The interval that begins at reset is never judged.
- R7: `glitch_flag` is sticky. Only a cycle with `glitch_clr` = 1 clears it, and a new short pulse in the same cycle takes priority over the clear.
- R8: `edge_stb` is high for exactly one cycle on each `level_out` transition in the selected direction: rising when `edge_neg` = 0, falling when `edge_neg` = 1. It stays low on transitions in the other direction.
- R9: While `rst_n` is low, and at release, `level_out`, `edge_stb` and `glitch_flag` are 0.
- R10: In de-bounce mode, short pulses never set `glitch_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz filter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | 1 | Unsynchronized input signal |
| time_sel | input | 4 | Hold-time setting index |
| mode_glitch | input | 1 | 0 = de-bounce, 1 = glitch-detect |
| edge_neg | input | 1 | 0 = strobe on rising, 1 = strobe on falling filtered edge |
| glitch_clr | input | 1 | Clears the sticky glitch flag |
| level_out | output | 1 | Filtered level |
| edge_stb | output | 1 | One-cycle strobe on the selected filtered edge |
| glitch_flag | output | 1 | Sticky short-pulse indicator |

## Verification
The embedded properties check several rules on every cycle. A de-bounced level moves only in a cycle where the hold count has completed. A glitch-mode level copies the synchronized input from one cycle earlier. The flag rises only from a short-pulse event seen in glitch mode, and it never drops without a clear. A strobe always coincides with a real level change.

Some behaviours can only be shown by the bench's scenarios. These are the exact latency for each hold-time setting, the restart of the wait after a bounce, the boundary between a pulse of N-1 cycles and one of N cycles, and the choice of strobe direction. The bench also runs a cycle model against randomized pulse trains whose widths straddle the limit.

// File: rtl/sigcond_pkg.sv
`timescale 1ns/1ps
package sigcond_pkg;

  typedef enum logic {
    FILT_DEBOUNCE = 1'b0,
    FILT_GLITCH   = 1'b1
  } filt_mode_e;

  localparam int unsigned SEL_W = 4;

  // Hold time of each setting in units of half a microsecond (R2).
  function automatic int unsigned half_us_of(input logic [SEL_W-1:0] sel);
    int unsigned h;
    case (sel)
      4'd0:  h = 1;
      4'd1:  h = 2;
      4'd2:  h = 4;
      4'd3:  h = 10;
      4'd4:  h = 20;
      4'd5:  h = 40;
      4'd6:  h = 100;
      4'd7:  h = 200;
      4'd8:  h = 400;
      4'd9:  h = 1000;
      4'd10: h = 2000;
      4'd11: h = 4000;
      4'd12: h = 10000;
      4'd13: h = 20000;
      4'd14: h = 40000;
      default: h = 50000;
    endcase
    return h;
  endfunction

  // Clock cycles for a setting, given the clock rate in MHz.
  function automatic int unsigned hold_cycles(input logic [SEL_W-1:0] sel,
                                              input int unsigned clk_mhz);
    return (half_us_of(sel) * clk_mhz) / 2;
  endfunction

endpackage

// File: rtl/sc_sync.sv
`timescale 1ns/1ps
module sc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sc_debounce.sv
`timescale 1ns/1ps
module sc_debounce
  import sigcond_pkg::*;
#(
  parameter int unsigned CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  filt_mode_e       mode,
  input  logic [CNT_W-1:0] limit,
  output logic             level,
  output logic             hold_done
);
  logic [CNT_W-1:0] cnt;
  logic             differ;

  assign differ    = (sync_in != level);
  assign hold_done = (mode == FILT_DEBOUNCE) && differ &&
                     (({1'b0, cnt} + 1'b1) >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
      cnt   <= '0;
    end else if (mode == FILT_GLITCH) begin
      level <= sync_in;
      cnt   <= '0;
    end else if (!differ) begin
      cnt   <= '0;
    end else if (hold_done) begin
      level <= sync_in;
      cnt   <= '0;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  // R3: a de-bounced level only moves when the hold count completed
  assert_hold_before_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FILT_DEBOUNCE && $past(mode) == FILT_DEBOUNCE && level != $past(level))
      |-> $past(hold_done));

  // R5: in glitch-detect mode the level is the synchronized input one cycle late
  assert_follow_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == FILT_GLITCH) |-> (level == $past(sync_in)));
endmodule

// File: rtl/sc_glitch.sv
`timescale 1ns/1ps
module sc_glitch
  import sigcond_pkg::*;
#(
  parameter int unsigned CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  filt_mode_e       mode,
  input  logic [CNT_W-1:0] limit,
  input  logic             clr,
  output logic             flag,
  output logic             short_pulse
);
  logic             prev;
  logic             seen;
  logic [CNT_W-1:0] run;
  logic             change;

  assign change      = (sync_in != prev);
  assign short_pulse = change && seen && (run < limit) && (mode == FILT_GLITCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      seen <= 1'b0;
      run  <= '0;
    end else begin
      prev <= sync_in;
      if (change) begin
        run  <= {{(CNT_W-1){1'b0}}, 1'b1};
        seen <= 1'b1;
      end else if (run != {CNT_W{1'b1}}) begin
        run  <= run + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           flag <= 1'b0;
    else if (short_pulse) flag <= 1'b1;
    else if (clr)         flag <= 1'b0;
  end

  // R7: flag never drops without a clear request
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag) && !$past(clr)) |-> flag);

  // R6: flag rises only after a detected short interval
  assert_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(short_pulse));

  // R10: flag never rises from a cycle spent in de-bounce mode
  assert_flag_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(mode) == FILT_GLITCH));
endmodule

// File: rtl/sc_edge.sv
`timescale 1ns/1ps
module sc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic neg_edge,
  output logic stb
);
  logic level_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_d <= 1'b0;
    else        level_d <= level;
  end

  assign stb = neg_edge ? (level_d & ~level) : (~level_d & level);

  // R8: a strobe always marks a real level change in the requested direction
  assert_strobe_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> (level != $past(level)) && (level == !neg_edge));
endmodule

// File: rtl/sig_conditioner.sv
`timescale 1ns/1ps
module sig_conditioner
  import sigcond_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 48,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw_in,
  input  logic [3:0] time_sel,
  input  logic       mode_glitch,
  input  logic       edge_neg,
  input  logic       glitch_clr,
  output logic       level_out,
  output logic       edge_stb,
  output logic       glitch_flag
);
  localparam int unsigned MAX_HOLD = hold_cycles(4'd15, CLK_MHZ);
  localparam int unsigned CNT_W    = $clog2(MAX_HOLD + 1);

  filt_mode_e       mode;
  logic [CNT_W-1:0] limit;
  logic             sync_lvl;
  logic             hold_done;
  logic             short_pulse;

  assign mode  = filt_mode_e'(mode_glitch);
  assign limit = CNT_W'(hold_cycles(time_sel, CLK_MHZ));

  sc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (sync_lvl)
  );

  sc_debounce #(.CNT_W(CNT_W)) u_deb (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_in   (sync_lvl),
    .mode      (mode),
    .limit     (limit),
    .level     (level_out),
    .hold_done (hold_done)
  );

  sc_glitch #(.CNT_W(CNT_W)) u_glitch (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_in     (sync_lvl),
    .mode        (mode),
    .limit       (limit),
    .clr         (glitch_clr),
    .flag        (glitch_flag),
    .short_pulse (short_pulse)
  );

  sc_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (level_out),
    .neg_edge (edge_neg),
    .stb      (edge_stb)
  );

  // R9: outputs quiet in the first cycle after reset release
  assert_reset_quiet_R9: assert property (@(posedge clk)
    $rose(rst_n) |-> (!glitch_flag && !edge_stb));
endmodule

// File: tb/sig_conditioner_test.sv
`timescale 1ns/1ps
module sig_conditioner_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raw_in = 1'b0;
  logic [3:0] time_sel = 4'd0;
  logic       mode_glitch = 1'b0;
  logic       edge_neg = 1'b0;
  logic       glitch_clr = 1'b0;
  logic       level_out, edge_stb, glitch_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sig_conditioner uut (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .time_sel(time_sel),
    .mode_glitch(mode_glitch), .edge_neg(edge_neg), .glitch_clr(glitch_clr),
    .level_out(level_out), .edge_stb(edge_stb), .glitch_flag(glitch_flag)
  );

  // R2: cycles = 48 * microseconds, microseconds follow a 1-2-5 series
  function automatic int exp_cycles(input int i);
    int mant, p;
    if (i == 0)  return 24;
    if (i == 15) return 25000 * 48;
    case ((i - 1) % 3)
      0: mant = 1;
      1: mant = 2;
      default: mant = 5;
    endcase
    p = 1;
    for (int k = 0; k < (i - 1) / 3; k++) p = p * 10;
    return mant * p * 48;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // Cycle model of the filter, advanced at every rising edge
  int m_s1, m_s2, m_out, m_outd, m_cnt, m_prev, m_seen, m_run, m_flag;
  localparam int RUN_SAT = 2097151;

  always @(posedge clk) begin
    int o_s1, o_s2, o_out, lim, chg, setf;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_out = 0; m_outd = 0; m_cnt = 0;
      m_prev = 0; m_seen = 0; m_run = 0; m_flag = 0;
    end else begin
      lim = exp_cycles(int'(time_sel));
      o_s1 = m_s1; o_s2 = m_s2; o_out = m_out;
      m_s1 = int'(raw_in);
      m_s2 = o_s1;
      m_outd = o_out;
      if (mode_glitch) begin
        m_out = o_s2; m_cnt = 0;
      end else if (o_s2 != o_out) begin
        m_cnt = m_cnt + 1;
        if (m_cnt >= lim) begin m_out = o_s2; m_cnt = 0; end
      end else begin
        m_cnt = 0;
      end
      chg  = (o_s2 != m_prev);
      setf = chg && m_seen && (m_run < lim) && mode_glitch;
      m_prev = o_s2;
      if (chg) begin m_run = 1; m_seen = 1; end
      else if (m_run < RUN_SAT) m_run = m_run + 1;
      if (setf) m_flag = 1;
      else if (glitch_clr) m_flag = 0;
    end
  end

  always @(negedge clk) begin
    int es;
    #2;
    if (rst_n) begin
      es = edge_neg ? (m_outd & ~m_out) : (~m_outd & m_out);
      if (mode_glitch) chk("R5 level", int'(level_out), m_out);
      else             chk("R3 level", int'(level_out), m_out);
      chk("R8 strobe", int'(edge_stb), es);
      chk("R6 flag", int'(glitch_flag), m_flag);
    end
  end

  // Latency from a raw toggle to the filtered level change
  task automatic latency(input int md, input int sel, input int expn, input string tag);
    int v, n;
    mode_glitch = md[0];
    time_sel = sel[3:0];
    v = int'(raw_in);
    repeat (exp_cycles(sel) + 5) tick();
    raw_in = ~raw_in;
    n = 0;
    while (n < expn + 10) begin
      tick();
      n++;
      if (int'(level_out) != v) break;
    end
    chk(tag, n, expn);
  endtask

  task automatic count_stb(input int cycles, output int hits);
    hits = 0;
    repeat (cycles) begin
      tick();
      if (edge_stb) hits++;
    end
  endtask

  initial begin
    int hits;
    void'($urandom(32'h5eed_1234));
    repeat (3) tick();
    chk("R9 level", int'(level_out), 0);
    chk("R9 strobe", int'(edge_stb), 0);
    chk("R9 flag", int'(glitch_flag), 0);
    rst_n = 1'b1;
    tick();
    chk("R9 flag after release", int'(glitch_flag), 0);

    // R1, R5: glitch-mode latency is three edges
    latency(1, 0, 3, "R1 sync latency");
    latency(1, 3, 3, "R5 follow latency");
    // R2, R3: de-bounce latency is hold time + 2 for settings 0..6
    for (int s = 0; s <= 6; s++) latency(0, s, exp_cycles(s) + 2, "R2 R3 hold latency");

    // R4, R10: bounces in de-bounce mode
    mode_glitch = 1'b0; time_sel = 4'd1;
    glitch_clr = 1'b1; tick(); glitch_clr = 1'b0;
    raw_in = 1'b1; repeat (100) tick();
    chk("R3 settled high", int'(level_out), 1);
    repeat (6) begin
      raw_in = 1'b0; repeat (5) tick();
      raw_in = 1'b1; repeat (5) tick();
    end
    raw_in = 1'b0; repeat (47) tick();
    raw_in = 1'b1; repeat (60) tick();
    chk("R4 bounce ignored", int'(level_out), 1);
    chk("R10 no flag in de-bounce", int'(glitch_flag), 0);
    raw_in = 1'b0; repeat (48 + 4) tick();
    chk("R3 full hold accepted", int'(level_out), 0);

    // R6, R7: glitch detection at the 48-cycle boundary
    mode_glitch = 1'b1;
    raw_in = 1'b1; repeat (100) tick();
    raw_in = 1'b0; repeat (47) tick();
    raw_in = 1'b1; repeat (6) tick();
    chk("R6 short pulse flagged", int'(glitch_flag), 1);
    repeat (200) tick();
    chk("R7 flag sticky", int'(glitch_flag), 1);
    glitch_clr = 1'b1; tick(); glitch_clr = 1'b0; tick();
    chk("R7 flag cleared", int'(glitch_flag), 0);
    repeat (100) tick();
    raw_in = 1'b0; repeat (48) tick();
    raw_in = 1'b1; repeat (6) tick();
    chk("R6 full-width pulse not flagged", int'(glitch_flag), 0);

    // R8: strobe direction
    edge_neg = 1'b0; raw_in = 1'b0; repeat (8) tick();
    raw_in = 1'b1; count_stb(8, hits);
    chk("R8 rising strobe", hits, 1);
    raw_in = 1'b0; count_stb(8, hits);
    chk("R8 no strobe on falling", hits, 0);
    edge_neg = 1'b1; tick();
    raw_in = 1'b1; count_stb(8, hits);
    chk("R8 no strobe on rising", hits, 0);
    raw_in = 1'b0; count_stb(8, hits);
    chk("R8 falling strobe", hits, 1);

    // Random pulse trains straddling the hold time
    for (int seg = 0; seg < 40; seg++) begin
      int lim, left, hold;
      mode_glitch = 1'($urandom_range(0, 1));
      time_sel    = 4'($urandom_range(0, 4));
      edge_neg    = 1'($urandom_range(0, 1));
      lim = exp_cycles(int'(time_sel));
      left = 1500;
      while (left > 0) begin
        hold = int'($urandom_range(1, 2 * lim + 2));
        if (hold > left) hold = left;
        raw_in = ~raw_in;
        repeat (hold) begin
          glitch_clr = ($urandom_range(0, 49) == 0);
          tick();
        end
        left -= hold;
      end
      glitch_clr = 1'b0;
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule